// File: doc/BRIEF.md
# SDRAM Bank State Tracker and Command Rule Checker

This block watches the decoded command stream of a four-bank double-data-rate SDRAM and keeps a model of each bank. A bank is in one of three states: idle, open with a row, or closing while its precharge time runs. Each bank has its own counters for the minimum row-open time, the precharge recovery time and the burst length. One shared counter covers the settle time after a mode-register load. The block works out the legality of every selected command from this model.

A legal command updates the model. An illegal command leaves the model unchanged and raises a one-cycle violation pulse with a 3-bit reason code. The block models three further behaviours: per-command auto precharge, the single-bank and all-bank forms of precharge, and burst terminate of an unfinished read. A precharge aimed at a bank that is already closed is accepted as a harmless no-op. The block sits beside a memory controller as a protocol monitor. All timing parameters are given in clock cycles.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset every bank reports idle and a row of 0, and no violation is flagged. The state codes are 0 idle, 1 open and 2 closing.
- R2: The cmd_op codes are 0 no-op, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge and 6 burst terminate. Code 7 acts as a no-op. While cmd_cs_n is high the command is ignored: no state changes and no violation is flagged.
- R3: A rejected command gives viol_o high for exactly the one cycle after it was sampled. viol_code_o then holds 1 (bank busy), 2 (row already open), 3 (no open row), 4 (timing not met) or 5 (illegal terminate). Otherwise it holds 0. A rejected command changes no bank state.
- R4: A mode load is accepted only when every bank is idle or has finished its precharge time; otherwise it is rejected with code 1. After an accepted mode load, any command other than a no-op within the following TMRD-1 cycles is rejected with code 4.
- R5: An activate to an idle bank opens it with the row taken from cmd_addr, and the new state and row show one cycle later. An activate to a bank that is open, or open with an auto precharge pending, is rejected with code 2.
- R6: A read or write is accepted only to an open bank that has no auto precharge pending. Otherwise it is rejected with code 3.
- R7: A precharge with cmd_a10 low closes only the bank named by cmd_bank. With cmd_a10 high it closes every open bank and ignores cmd_bank. It is rejected with code 4 if any bank it would close was activated fewer than TRAS cycles earlier; in that case no bank closes.
- R8: A single-bank precharge aimed at a bank that is idle or already closing is accepted as a no-op, with no violation.
- R9: A closing bank accepts an activate from exactly TRP cycles after its precharge started; earlier activates get code 4. It reports idle after that cycle.
- R10: A read or write with cmd_a10 high starts the bank's precharge on its own, in whichever comes later: BURST_CYC cycles after the command, or TRAS cycles after the bank's activate.
- R11: A burst terminate is accepted only within BURST_CYC-1 cycles after a read without auto precharge that has not been cut short already. A write in between cuts the read short. An accepted terminate leaves the bank open. Any other terminate gets code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_op | input | 3 | Decoded command code |
| cmd_bank | input | BANK_W | Bank address |
| cmd_addr | input | ROW_W | Row address for activate |
| cmd_a10 | input | 1 | Auto-precharge / all-banks flag |
| bank_state_o | output | 2*NB | State of each bank, 2 bits per bank, bank 0 in the low bits |
| bank_row_o | output | ROW_W*NB | Row last opened in each bank, bank 0 in the low bits |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Reason code for the violation |

## Verification
The assertions check, on every cycle, that each bank opens only from a ready state, that no bank leaves the open state before its row-open window expires, and that an automatic close happens only after an armed burst has run out. They also check that a command during the mode-load window is always flagged, that a single-bank precharge of a closed bank never is, and that an orphan terminate is always coded 5. The bench scenarios are needed for the exact cycles: when a bank returns to idle, when an auto precharge held back by the row-open window takes effect, and how the all-bank precharge treats bank addresses and mixed bank ages.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_LMR = 3'd1, OP_ACT = 3'd2, OP_RD = 3'd3,
    OP_WR  = 3'd4, OP_PRE = 3'd5, OP_BST = 3'd6, OP_RSV = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0, BK_OPEN = 2'd1, BK_CLOSING = 2'd2
  } bank_st_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_BUSY = 3'd1, ERR_ROW_OPEN = 3'd2,
    ERR_NO_ROW = 3'd3, ERR_TIMING = 3'd4, ERR_BAD_TERM = 3'd5
  } err_e;

  // width of a down-counter that starts at cycles-1
  function automatic int unsigned cnt_width(int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles);
  endfunction

  // value loaded so that the counter reads zero exactly 'cycles' edges later
  function automatic int unsigned cnt_load(int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  function automatic logic is_exec(logic [2:0] op);
    return (op != OP_NOP) && (op != OP_RSV);
  endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_guard_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int TRAS      = 6,
  parameter int TRP       = 3,
  parameter int BURST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             arm_go,
  input  logic             pre_go,
  input  logic [ROW_W-1:0] row_in,
  output bank_st_e         state_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ready_o,
  output logic             ras_met_o,
  output logic             ap_pend_o
);

  localparam int RAS_W = cnt_width(TRAS);
  localparam int RP_W  = cnt_width(TRP);
  localparam int BC_W  = cnt_width(BURST_CYC);

  bank_st_e         state;
  logic [ROW_W-1:0] row_q;
  logic [RAS_W-1:0] ras_cnt;
  logic [RP_W-1:0]  rp_cnt;
  logic [BC_W-1:0]  burst_cnt;
  logic             ap_pend;

  // named internal events
  logic rp_done, burst_done, ap_fire;
  assign rp_done    = (rp_cnt == '0);
  assign burst_done = (burst_cnt == '0);
  assign ap_fire    = (state == BK_OPEN) && ap_pend && burst_done && (ras_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= BK_IDLE;
      row_q     <= '0;
      ras_cnt   <= '0;
      rp_cnt    <= '0;
      burst_cnt <= '0;
      ap_pend   <= 1'b0;
    end else begin
      if (ras_cnt != '0)   ras_cnt   <= ras_cnt - 1'b1;
      if (!rp_done)        rp_cnt    <= rp_cnt - 1'b1;
      if (!burst_done)     burst_cnt <= burst_cnt - 1'b1;
      if (act_go) begin
        state   <= BK_OPEN;
        row_q   <= row_in;
        ras_cnt <= RAS_W'(cnt_load(TRAS));
        ap_pend <= 1'b0;
      end else if (pre_go || ap_fire) begin
        state   <= BK_CLOSING;
        rp_cnt  <= RP_W'(cnt_load(TRP));
        ap_pend <= 1'b0;
      end else if (arm_go) begin
        ap_pend   <= 1'b1;
        burst_cnt <= BC_W'(cnt_load(BURST_CYC));
      end else if (state == BK_CLOSING && rp_done) begin
        state <= BK_IDLE;
      end
    end
  end

  assign state_o   = state;
  assign row_o     = row_q;
  assign ready_o   = (state == BK_IDLE) || (state == BK_CLOSING && rp_done);
  assign ras_met_o = (ras_cnt == '0);
  assign ap_pend_o = ap_pend;

  // R9
  open_from_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BK_OPEN && $past(state) != BK_OPEN) |-> $past(ready_o));

  // R7
  close_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BK_CLOSING && $past(state) == BK_OPEN) |-> ($past(ras_cnt) == '0));

  // R10
  auto_close_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BK_CLOSING && $past(state) == BK_OPEN && !$past(pre_go))
      |-> ($past(ap_pend) && $past(burst_cnt) == '0));

endmodule

// File: rtl/sdram_cmd_judge.sv
module sdram_cmd_judge
  import sdram_guard_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              sel,
  input  logic [2:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic              a10,
  input  logic              mrd_busy,
  input  logic              rd_live,
  input  logic              rd_ap,
  input  logic [NB-1:0]     ready,
  input  logic [NB-1:0]     is_open,
  input  logic [NB-1:0]     ap_pend,
  input  logic [NB-1:0]     ras_met,
  output logic [2:0]        err,
  output logic [NB-1:0]     act_en,
  output logic [NB-1:0]     arm_en,
  output logic [NB-1:0]     pre_en,
  output logic              lmr_go,
  output logic              rd_go,
  output logic              wr_go,
  output logic              bst_go
);

  logic [NB-1:0] closable;
  assign closable = is_open & ~ap_pend;

  always_comb begin
    err    = ERR_NONE;
    act_en = '0;
    arm_en = '0;
    pre_en = '0;
    lmr_go = 1'b0;
    rd_go  = 1'b0;
    wr_go  = 1'b0;
    bst_go = 1'b0;
    if (sel && is_exec(op)) begin
      if (mrd_busy) begin
        err = ERR_TIMING;
      end else begin
        case (op)
          OP_LMR: if (!(&ready)) err = ERR_BUSY; else lmr_go = 1'b1;
          OP_ACT: begin
            if (is_open[bank])     err = ERR_ROW_OPEN;
            else if (!ready[bank]) err = ERR_TIMING;
            else                   act_en[bank] = 1'b1;
          end
          OP_RD, OP_WR: begin
            if (!closable[bank]) err = ERR_NO_ROW;
            else begin
              arm_en[bank] = a10;
              rd_go = (op == OP_RD);
              wr_go = (op == OP_WR);
            end
          end
          OP_PRE: begin
            if (a10) begin
              if (|(closable & ~ras_met)) err = ERR_TIMING;
              else pre_en = closable;
            end else if (closable[bank]) begin
              if (!ras_met[bank]) err = ERR_TIMING;
              else pre_en[bank] = 1'b1;
            end
          end
          OP_BST: if (rd_live && !rd_ap) bst_go = 1'b1; else err = ERR_BAD_TERM;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import sdram_guard_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int TMRD      = 2,
  parameter int TRAS      = 6,
  parameter int TRP       = 3,
  parameter int BURST_CYC = 4,
  localparam int NB       = 1 << BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_cs_n,
  input  logic [2:0]          cmd_op,
  input  logic [BANK_W-1:0]   cmd_bank,
  input  logic [ROW_W-1:0]    cmd_addr,
  input  logic                cmd_a10,
  output logic [2*NB-1:0]     bank_state_o,
  output logic [ROW_W*NB-1:0] bank_row_o,
  output logic                viol_o,
  output logic [2:0]          viol_code_o
);

  localparam int MRD_W = cnt_width(TMRD);
  localparam int RD_W  = cnt_width(BURST_CYC);

  logic [MRD_W-1:0] mrd_cnt;
  logic [RD_W-1:0]  rd_cnt;
  logic             rd_ap;
  logic [NB-1:0]    ready, is_open, ap_pend, ras_met;
  logic [NB-1:0]    act_en, arm_en, pre_en;
  logic             lmr_go, rd_go, wr_go, bst_go;
  logic [2:0]       err;
  bank_st_e         st_vec [NB];

  sdram_cmd_judge #(.BANK_W(BANK_W)) u_judge (
    .sel(!cmd_cs_n), .op(cmd_op), .bank(cmd_bank), .a10(cmd_a10),
    .mrd_busy(mrd_cnt != '0), .rd_live(rd_cnt != '0), .rd_ap(rd_ap),
    .ready(ready), .is_open(is_open), .ap_pend(ap_pend), .ras_met(ras_met),
    .err(err), .act_en(act_en), .arm_en(arm_en), .pre_en(pre_en),
    .lmr_go(lmr_go), .rd_go(rd_go), .wr_go(wr_go), .bst_go(bst_go)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [ROW_W-1:0] row_b;
    sdram_bank_fsm #(.ROW_W(ROW_W), .TRAS(TRAS), .TRP(TRP), .BURST_CYC(BURST_CYC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_go(act_en[b]), .arm_go(arm_en[b]), .pre_go(pre_en[b]),
      .row_in(cmd_addr), .state_o(st_vec[b]), .row_o(row_b),
      .ready_o(ready[b]), .ras_met_o(ras_met[b]), .ap_pend_o(ap_pend[b])
    );
    assign is_open[b]              = (st_vec[b] == BK_OPEN);
    assign bank_state_o[2*b +: 2]  = st_vec[b];
    assign bank_row_o[ROW_W*b +: ROW_W] = row_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_cnt     <= '0;
      rd_cnt      <= '0;
      rd_ap       <= 1'b0;
      viol_o      <= 1'b0;
      viol_code_o <= ERR_NONE;
    end else begin
      if (lmr_go)              mrd_cnt <= MRD_W'(cnt_load(TMRD));
      else if (mrd_cnt != '0)  mrd_cnt <= mrd_cnt - 1'b1;
      if (rd_go) begin
        rd_cnt <= RD_W'(cnt_load(BURST_CYC));
        rd_ap  <= cmd_a10;
      end else if (bst_go || wr_go) begin
        rd_cnt <= '0;
      end else if (rd_cnt != '0) begin
        rd_cnt <= rd_cnt - 1'b1;
      end
      viol_o      <= (err != ERR_NONE);
      viol_code_o <= err;
    end
  end

  // R4
  mrd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cs_n && is_exec(cmd_op) && mrd_cnt != '0) |=> (viol_o && viol_code_o == ERR_TIMING));

  // R3
  viol_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> ($past(!cmd_cs_n) && is_exec($past(cmd_op))));

  // R3
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o |-> (viol_code_o == ERR_NONE));

  // R8
  pre_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cs_n && cmd_op == OP_PRE && !cmd_a10 && mrd_cnt == '0 &&
     st_vec[cmd_bank] != BK_OPEN) |=> !viol_o);

  // R11
  bst_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cs_n && cmd_op == OP_BST && mrd_cnt == '0 && rd_cnt == '0)
      |=> (viol_code_o == ERR_BAD_TERM));

endmodule

// File: tb/test_sdram_bank_guard.sv
module test_sdram_bank_guard;

  localparam int BANK_W = 2, ROW_W = 13, NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_cs_n = 1'b1;
  logic [2:0] cmd_op = 3'd0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [ROW_W-1:0] cmd_addr = '0;
  logic cmd_a10 = 1'b0;
  logic [2*NB-1:0] bank_state_o;
  logic [ROW_W*NB-1:0] bank_row_o;
  logic viol_o;
  logic [2:0] viol_code_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_bank_guard #(.BANK_W(BANK_W), .ROW_W(ROW_W), .TMRD(2), .TRAS(6), .TRP(3), .BURST_CYC(4))
  i_sdram_bank_guard (
    .clk(clk), .rst_n(rst_n), .cmd_cs_n(cmd_cs_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_a10(cmd_a10), .bank_state_o(bank_state_o),
    .bank_row_o(bank_row_o), .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  // {req[3:0], cs_n, op[2:0], bank[1:0], a10, row[12:0], expected code[2:0]}
  localparam int NV = 38;
  localparam logic [26:0] VEC [NV] = '{
    {4'd4,  1'b0, 3'd1, 2'd0, 1'b0, 13'd0,    3'd0}, // R4 mode load, all idle
    {4'd4,  1'b0, 3'd2, 2'd0, 1'b0, 13'd5,    3'd4}, // R4 inside load window
    {4'd5,  1'b0, 3'd2, 2'd0, 1'b0, 13'd5,    3'd0}, // R5 open bank 0
    {4'd5,  1'b0, 3'd2, 2'd0, 1'b0, 13'd7,    3'd2}, // R5 row already open
    {4'd6,  1'b0, 3'd3, 2'd1, 1'b0, 13'd0,    3'd3}, // R6 read of idle bank
    {4'd7,  1'b0, 3'd5, 2'd0, 1'b0, 13'd0,    3'd4}, // R7 precharge too early
    {4'd4,  1'b0, 3'd1, 2'd0, 1'b0, 13'd0,    3'd1}, // R4 load with open bank
    {4'd6,  1'b0, 3'd3, 2'd0, 1'b0, 13'd0,    3'd0}, // R6 read
    {4'd11, 1'b0, 3'd6, 2'd0, 1'b0, 13'd0,    3'd0}, // R11 terminate read
    {4'd11, 1'b0, 3'd6, 2'd0, 1'b0, 13'd0,    3'd5}, // R11 second terminate
    {4'd8,  1'b0, 3'd5, 2'd1, 1'b0, 13'd0,    3'd0}, // R8 idle bank no-op
    {4'd7,  1'b0, 3'd5, 2'd0, 1'b0, 13'd0,    3'd0}, // R7 close bank 0
    {4'd9,  1'b0, 3'd2, 2'd0, 1'b0, 13'd9,    3'd4}, // R9 before recovery
    {4'd8,  1'b0, 3'd5, 2'd0, 1'b0, 13'd0,    3'd0}, // R8 closing bank no-op
    {4'd9,  1'b0, 3'd2, 2'd0, 1'b0, 13'd9,    3'd0}, // R9 exactly TRP later
    {4'd2,  1'b1, 3'd2, 2'd0, 1'b0, 13'd1234, 3'd0}, // R2 deselected
    {4'd10, 1'b0, 3'd4, 2'd0, 1'b1, 13'd0,    3'd0}, // R10 write + auto close
    {4'd6,  1'b0, 3'd3, 2'd0, 1'b0, 13'd0,    3'd3}, // R6 auto close pending
    {4'd11, 1'b0, 3'd6, 2'd0, 1'b0, 13'd0,    3'd5}, // R11 no live read
    {4'd5,  1'b0, 3'd2, 2'd2, 1'b0, 13'd3,    3'd0}, // R5 open bank 2
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}, // R3
    {4'd9,  1'b0, 3'd2, 2'd0, 1'b0, 13'd1,    3'd4}, // R9 auto close recovering
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}, // R3
    {4'd9,  1'b0, 3'd2, 2'd0, 1'b0, 13'd1,    3'd0}, // R9 reopen bank 0
    {4'd7,  1'b0, 3'd5, 2'd0, 1'b1, 13'd0,    3'd4}, // R7 all-close, bank 0 young
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}, // R3
    {4'd3,  1'b0, 3'd7, 2'd0, 1'b0, 13'd0,    3'd0}, // R3 code 7 is no-op
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}, // R3
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}, // R3
    {4'd7,  1'b0, 3'd5, 2'd0, 1'b1, 13'd0,    3'd0}, // R7 all-close accepted
    {4'd4,  1'b0, 3'd1, 2'd0, 1'b0, 13'd0,    3'd1}, // R4 banks still recovering
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}, // R3
    {4'd4,  1'b0, 3'd1, 2'd0, 1'b0, 13'd0,    3'd0}, // R4 load accepted
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}, // R3
    {4'd5,  1'b0, 3'd2, 2'd3, 1'b0, 13'd2,    3'd0}, // R5 open bank 3
    {4'd10, 1'b0, 3'd3, 2'd3, 1'b1, 13'd0,    3'd0}, // R10 read + auto close
    {4'd11, 1'b0, 3'd6, 2'd0, 1'b0, 13'd0,    3'd5}, // R11 read had auto close
    {4'd3,  1'b0, 3'd0, 2'd0, 1'b0, 13'd0,    3'd0}  // R3
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st(input int b);
    return int'(bank_state_o[2*b +: 2]);
  endfunction

  function automatic int rw(input int b);
    return int'(bank_row_o[ROW_W*b +: ROW_W]);
  endfunction

  task automatic step(input logic cs, input logic [2:0] op, input logic [1:0] bk,
                      input logic a10, input logic [12:0] row);
    @(negedge clk);
    cmd_cs_n = cs; cmd_op = op; cmd_bank = bk; cmd_a10 = a10; cmd_addr = row;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_cs_n = 1'b1; cmd_op = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int b = 0; b < NB; b++) begin
      chk("R1 state", st(b), 0);
      chk("R1 row", rw(b), 0);
    end
    chk("R1 viol", int'(viol_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      step(v[22], v[21:19], v[18:17], v[16], v[15:3]);
      if ({viol_o, viol_code_o} != {(v[2:0] != 3'd0), v[2:0]}) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual=%0d/%0d expected=%0d/%0d", v[26:23], i,
                 viol_o, viol_code_o, (v[2:0] != 3'd0), v[2:0]);
      end
      n_chk++;
    end
    // R5 rows kept, R9 banks back to idle
    chk("R5 row b0", rw(0), 1);
    chk("R5 row b3", rw(3), 2);
    chk("R9 b0 idle", st(0), 0);
    chk("R9 b2 idle", st(2), 0);
    chk("R5 b3 open", st(3), 1);
    // R10: auto close of bank 3 held back by TRAS (edge 40, not 39)
    step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    chk("R10 b3 still open", st(3), 1);
    step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    chk("R10 b3 closing", st(3), 2);
    step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    chk("R9 b3 closing", st(3), 2);
    step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    chk("R9 b3 idle", st(3), 0);

    // directed: deselect, single and all-bank close
    do_reset();
    step(1'b0, 3'd2, 2'd1, 1'b0, 13'd100);
    chk("R5 b1 open", st(1), 1);
    chk("R5 b1 row", rw(1), 100);
    step(1'b1, 3'd2, 2'd1, 1'b0, 13'd200);
    chk("R2 row kept", rw(1), 100);
    chk("R2 no viol", int'(viol_o), 0);
    step(1'b1, 3'd2, 2'd2, 1'b0, 13'd50);
    chk("R2 b2 idle", st(2), 0);
    step(1'b0, 3'd2, 2'd2, 1'b0, 13'd300);
    for (int k = 0; k < 5; k++) step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    step(1'b0, 3'd5, 2'd1, 1'b0, 13'd0);
    chk("R7 b1 closing", st(1), 2);
    chk("R7 b2 untouched", st(2), 1);
    step(1'b0, 3'd5, 2'd3, 1'b1, 13'd0);
    chk("R7 all b2 closing", st(2), 2);
    chk("R7 all no viol", int'(viol_o), 0);
    step(1'b0, 3'd0, 2'd0, 1'b0, 13'd0);
    step(1'b0, 3'd2, 2'd1, 1'b0, 13'd77);
    chk("R9 reopen ok", int'(viol_o), 0);
    chk("R9 reopen state", st(1), 1);
    chk("R5 reopen row", rw(1), 77);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule